// File: doc/BRIEF.md
# Masked Vector Multishift Byte Extractor

This block takes a vector of 64-bit data lanes and a vector of control bytes, eight per lane. Every control byte chooses an 8-bit window inside its own lane's data word, starting at any bit position. A window that runs past the top bit continues from bit 0 of the same word. The eight windows of a lane become the eight result bytes of that lane. A single instruction therefore performs many independent rotate-and-extract operations.

A per-byte write mask decides which result bytes are written. Each unselected byte either keeps the matching byte of a separately supplied previous-destination vector or becomes zero. The vector length can be set to 128, 256 or 512 bits. Lanes above the active length are forced to zero. A broadcast option makes every lane read lane 0's data word.

The result is captured in one output register. The register loads only when the input is valid, and an output valid flag follows one cycle later.

Top module: `multishift_unit`

## Requirements
- R1: For result byte j of lane i, bit k (k = 0..7) equals bit ((c + k) mod 64) of the lane's data word, where c is control byte j of lane i. A window that passes bit 63 wraps to bit 0. Control byte j of lane i sits at ctrlVec bits [64*i+8*j+7 : 64*i+8*j], and the result byte sits at the same position in result.
- R2: Bits 7:6 of every control byte are ignored. Only bits 5:0 set the window start, so changing bits 7:6 does not change the result.
- R3: When maskEn is 0, every computed byte is written. When maskEn is 1, byte j of lane i is written only if wrMask bit 8*i+j is 1.
- R4: In merge mode (zeroMode = 0), a byte whose mask bit is 0 takes the matching byte of oldDest.
- R5: In zeroing mode (zeroMode = 1), a byte whose mask bit is 0 becomes 0x00.
- R6: vecLen 0, 1, 2 and 3 select 2, 4, 8 and 8 active lanes (128, 256, 512 and 512 bits). All result bits above the active length are 0.
- R7: When bcastEn is 1, every active lane uses lane 0's data word (dataVec[63:0]) instead of its own.
- R8: outValid equals inValid delayed by exactly one clock. The result register loads only on cycles where inValid is 1 and otherwise holds its value.
- R9: A synchronous active-high reset clears result and outValid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input operands are valid this cycle |
| vecLen | input | 2 | Vector length select: 0=128, 1=256, 2 or 3=512 bits |
| bcastEn | input | 1 | All lanes use lane 0 data word |
| maskEn | input | 1 | Apply the per-byte write mask |
| zeroMode | input | 1 | 1: unselected bytes become zero; 0: unselected bytes are merged from oldDest |
| wrMask | input | 64 | Write mask, bit 8*i+j covers byte j of lane i |
| ctrlVec | input | 512 | Control bytes, eight per lane |
| dataVec | input | 512 | Data words, one per 64-bit lane |
| oldDest | input | 512 | Previous destination value used for merging |
| outValid | output | 1 | Result register holds a new value |
| result | output | 512 | Registered result vector |

## Verification
The hardest case to reach is a window start near the top of the lane, where the window has to wrap. Random data and control values seldom land exactly on offsets 57 to 63 with a recognisable bit pattern. The bench therefore uses a directed vector with known bits at both ends of lane 0 and a start offset of 60, and it checks the exact expected byte.

Table entries cover every vecLen code, including code 3, with broadcast, merge and zeroing active. A further test flips only bits 7:6 of every control byte to show they have no effect. Another test shows the register holding its value while inValid is low and the other inputs change.

// File: rtl/msx_pkg.sv
package msx_pkg;
  localparam int LANE_BITS      = 64;
  localparam int BYTE_BITS      = 8;
  localparam int MAX_LANES      = 8;
  localparam int BYTES_PER_LANE = LANE_BITS / BYTE_BITS;
  localparam int VEC_BITS       = MAX_LANES * LANE_BITS;
  localparam int MASK_BITS      = MAX_LANES * BYTES_PER_LANE;
  localparam int OFS_BITS       = $clog2(LANE_BITS);
  localparam int LEN_BITS       = 2;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic                 loadEn;
    logic                 bcastSel;
    logic                 maskOn;
    logic                 zeroFill;
    logic [MAX_LANES-1:0] laneActive;
  } msxStrobes_t;
endpackage

// File: rtl/msx_ctrl.sv
module msx_ctrl
  import msx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [LEN_BITS-1:0] vecLen,
  input  logic                bcastEn,
  input  logic                maskEn,
  input  logic                zeroMode,
  output msxStrobes_t         strb,
  output logic                outValid
);
  localparam int QUARTER = MAX_LANES / 4;
  localparam int HALF    = MAX_LANES / 2;

  function automatic int lanesFor(input logic [LEN_BITS-1:0] sel);
    case (sel)
      2'd0:    lanesFor = QUARTER;
      2'd1:    lanesFor = HALF;
      default: lanesFor = MAX_LANES;
    endcase
  endfunction

  logic [MAX_LANES-1:0] laneOn;

  generate
    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane_on
      assign laneOn[g] = (g < lanesFor(vecLen));
    end
  endgenerate

  always_comb begin
    strb.loadEn     = inValid;
    strb.bcastSel   = bcastEn;
    strb.maskOn     = maskEn;
    strb.zeroFill   = zeroMode;
    strb.laneActive = laneOn;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/msx_lane.sv
module msx_lane
  import msx_pkg::*;
(
  input  logic [LANE_BITS-1:0]      dataWord,
  input  logic [LANE_BITS-1:0]      ctrlWord,
  input  logic [LANE_BITS-1:0]      oldWord,
  input  logic [BYTES_PER_LANE-1:0] maskBits,
  input  logic                      laneOn,
  input  logic                      maskOn,
  input  logic                      zeroFill,
  output logic [LANE_BITS-1:0]      nextWord
);
  // Doubling the word turns a wrapping window into a plain part-select
  logic [2*LANE_BITS-1:0] doubled;
  assign doubled = {dataWord, dataWord};

  generate
    for (genvar j = 0; j < BYTES_PER_LANE; j++) begin : g_byte
      logic [OFS_BITS-1:0]  startBit;
      logic [BYTE_BITS-1:0] window;
      logic                 writeIt;

      assign startBit = ctrlWord[j*BYTE_BITS +: OFS_BITS];
      assign window   = doubled[startBit +: BYTE_BITS];
      assign writeIt  = !maskOn || maskBits[j];

      always_comb begin
        if (!laneOn)       nextWord[j*BYTE_BITS +: BYTE_BITS] = '0;
        else if (writeIt)  nextWord[j*BYTE_BITS +: BYTE_BITS] = window;
        else if (zeroFill) nextWord[j*BYTE_BITS +: BYTE_BITS] = '0;
        else               nextWord[j*BYTE_BITS +: BYTE_BITS] = oldWord[j*BYTE_BITS +: BYTE_BITS];
      end
    end
  endgenerate
endmodule

// File: rtl/msx_datapath.sv
module msx_datapath
  import msx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  msxStrobes_t          strb,
  input  logic [MASK_BITS-1:0] wrMask,
  input  logic [VEC_BITS-1:0]  ctrlVec,
  input  logic [VEC_BITS-1:0]  dataVec,
  input  logic [VEC_BITS-1:0]  oldDest,
  output logic [VEC_BITS-1:0]  result
);
  logic [VEC_BITS-1:0] nextVec;

  generate
    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
      logic [LANE_BITS-1:0] srcWord;
      assign srcWord = strb.bcastSel ? dataVec[LANE_BITS-1:0]
                                     : dataVec[i*LANE_BITS +: LANE_BITS];

      msx_lane u_lane (
        .dataWord (srcWord),
        .ctrlWord (ctrlVec[i*LANE_BITS +: LANE_BITS]),
        .oldWord  (oldDest[i*LANE_BITS +: LANE_BITS]),
        .maskBits (wrMask[i*BYTES_PER_LANE +: BYTES_PER_LANE]),
        .laneOn   (strb.laneActive[i]),
        .maskOn   (strb.maskOn),
        .zeroFill (strb.zeroFill),
        .nextWord (nextVec[i*LANE_BITS +: LANE_BITS])
      );

      assert_inactive_zero_R6: assert property (@(posedge clk) disable iff (rst)
        strb.loadEn && !strb.laneActive[i] |=> result[i*LANE_BITS +: LANE_BITS] == '0);
    end

    for (genvar b = 0; b < MASK_BITS; b++) begin : g_byte_chk
      assert_zeroing_R5: assert property (@(posedge clk) disable iff (rst)
        strb.loadEn && strb.maskOn && strb.zeroFill && !wrMask[b]
        |=> result[b*BYTE_BITS +: BYTE_BITS] == '0);
      assert_merge_R4: assert property (@(posedge clk) disable iff (rst)
        strb.loadEn && strb.maskOn && !strb.zeroFill && !wrMask[b]
        && strb.laneActive[b/BYTES_PER_LANE]
        |=> result[b*BYTE_BITS +: BYTE_BITS] == $past(oldDest[b*BYTE_BITS +: BYTE_BITS]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)              result <= '0;
    else if (strb.loadEn) result <= nextVec;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strb.loadEn |=> $stable(result));
  assert_min_lanes_R6: assert property (@(posedge clk) disable iff (rst)
    strb.laneActive[1:0] == 2'b11);
endmodule

// File: rtl/multishift_unit.sv
module multishift_unit
  import msx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [LEN_BITS-1:0]  vecLen,
  input  logic                 bcastEn,
  input  logic                 maskEn,
  input  logic                 zeroMode,
  input  logic [MASK_BITS-1:0] wrMask,
  input  logic [VEC_BITS-1:0]  ctrlVec,
  input  logic [VEC_BITS-1:0]  dataVec,
  input  logic [VEC_BITS-1:0]  oldDest,
  output logic                 outValid,
  output logic [VEC_BITS-1:0]  result
);
  msxStrobes_t strb;

  msx_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .vecLen   (vecLen),
    .bcastEn  (bcastEn),
    .maskEn   (maskEn),
    .zeroMode (zeroMode),
    .strb     (strb),
    .outValid (outValid)
  );

  msx_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .wrMask  (wrMask),
    .ctrlVec (ctrlVec),
    .dataVec (dataVec),
    .oldDest (oldDest),
    .result  (result)
  );

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (result == '0 && !outValid));
endmodule

// File: tb/multishift_unit_test.sv
module multishift_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [1:0]   vecLen;
  logic         bcastEn, maskEn, zeroMode;
  logic [63:0]  wrMask;
  logic [511:0] ctrlVec, dataVec, oldDest;
  logic         outValid;
  logic [511:0] result;

  int checks = 0;
  int fails  = 0;

  multishift_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .vecLen(vecLen),
    .bcastEn(bcastEn), .maskEn(maskEn), .zeroMode(zeroMode), .wrMask(wrMask),
    .ctrlVec(ctrlVec), .dataVec(dataVec), .oldDest(oldDest),
    .outValid(outValid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]  len;
    logic        bc;
    logic        me;
    logic        zm;
    logic [15:0] seed;
  } vecEntry_t;

  localparam vecEntry_t TABLE [10] = '{
    '{2'd2, 1'b0, 1'b0, 1'b0, 16'h0011},  // R1 R3 full width, no mask
    '{2'd0, 1'b0, 1'b0, 1'b0, 16'h0022},  // R6 128-bit
    '{2'd1, 1'b0, 1'b0, 1'b0, 16'h0033},  // R6 256-bit
    '{2'd3, 1'b0, 1'b0, 1'b0, 16'h0044},  // R6 code 3 acts as 512
    '{2'd2, 1'b1, 1'b0, 1'b0, 16'h0055},  // R7 broadcast
    '{2'd1, 1'b1, 1'b1, 1'b1, 16'h0066},  // R7 R5
    '{2'd2, 1'b0, 1'b1, 1'b0, 16'h0077},  // R3 R4 merge
    '{2'd2, 1'b0, 1'b1, 1'b1, 16'h0088},  // R3 R5 zeroing
    '{2'd0, 1'b0, 1'b1, 1'b0, 16'h0099},  // R4 R6 merge at 128
    '{2'd3, 1'b1, 1'b1, 1'b0, 16'h00AA}   // R4 R7
  };

  function automatic logic [63:0] mix(input logic [15:0] seed, input int idx);
    logic [63:0] x;
    x = {48'h0, seed} * 64'h9E3779B97F4A7C15 + 64'(idx) * 64'hD1B54A32D192ED03;
    x = x ^ (x >> 29);
    x = x * 64'hBF58476D1CE4E5B9;
    return x ^ (x >> 31);
  endfunction

  function automatic logic [511:0] model(
    input logic [1:0] len, input logic bc, input logic me, input logic zm,
    input logic [63:0] msk, input logic [511:0] cv, input logic [511:0] dv,
    input logic [511:0] od);
    logic [511:0] r;
    int lanes;
    r = '0;
    lanes = (len == 2'd0) ? 2 : (len == 2'd1) ? 4 : 8;
    for (int i = 0; i < lanes; i++) begin
      logic [63:0] d;
      d = bc ? dv[63:0] : dv[i*64 +: 64];
      for (int j = 0; j < 8; j++) begin
        int c;
        logic [7:0] byteVal;
        c = int'(cv[i*64 + j*8 +: 8]) % 64;
        for (int k = 0; k < 8; k++) byteVal[k] = d[(c + k) % 64];
        if (!me || msk[i*8 + j]) r[i*64 + j*8 +: 8] = byteVal;
        else if (zm)             r[i*64 + j*8 +: 8] = 8'h00;
        else                     r[i*64 + j*8 +: 8] = od[i*64 + j*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fillFromSeed(input logic [15:0] seed);
    for (int i = 0; i < 8; i++) begin
      ctrlVec[i*64 +: 64] = mix(seed, i);
      dataVec[i*64 +: 64] = mix(seed, i + 8);
      oldDest[i*64 +: 64] = mix(seed, i + 16);
    end
    wrMask = mix(seed, 24);
  endtask

  // Drive at negedge, the register loads at posedge, sample at the next negedge
  task automatic pulse(output logic [511:0] exp);
    exp = model(vecLen, bcastEn, maskEn, zeroMode, wrMask, ctrlVec, dataVec, oldDest);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [511:0] exp;
    logic [511:0] held;
    rst = 1'b1; inValid = 1'b0; vecLen = 2'd2; bcastEn = 1'b0; maskEn = 1'b0;
    zeroMode = 1'b0; wrMask = '0; ctrlVec = '0; dataVec = '0; oldDest = '0;
    repeat (3) @(negedge clk);
    check("R9 reset result", result, '0);
    check("R9 reset outValid", {511'b0, outValid}, 512'b0);
    rst = 1'b0;
    @(negedge clk);

    foreach (TABLE[t]) begin
      vecLen = TABLE[t].len; bcastEn = TABLE[t].bc;
      maskEn = TABLE[t].me;  zeroMode = TABLE[t].zm;
      fillFromSeed(TABLE[t].seed);
      pulse(exp);
      check("R8 outValid high", {511'b0, outValid}, 512'b1);
      check("R1 R3 R4 R5 R6 R7 table", result, exp);
    end

    // R1 wrap-around: window starts at bit 60, known pattern gives 0xF8
    vecLen = 2'd2; bcastEn = 1'b0; maskEn = 1'b0; zeroMode = 1'b0;
    dataVec = '0; dataVec[63:0] = 64'h8000_0000_0000_000F;
    ctrlVec = '0; ctrlVec[7:0] = 8'd60;
    pulse(exp);
    check("R1 wrap byte", {504'b0, result[7:0]}, {504'b0, 8'hF8});
    check("R1 wrap full", result, exp);

    // R2: bits 7:6 of the control bytes have no effect
    fillFromSeed(16'h0123);
    for (int b = 0; b < 64; b++) ctrlVec[b*8 +: 6] = 6'(b);
    for (int b = 0; b < 64; b++) ctrlVec[b*8+6 +: 2] = 2'b00;
    pulse(exp);
    held = result;
    for (int b = 0; b < 64; b++) ctrlVec[b*8+6 +: 2] = 2'(b + 1);
    pulse(exp);
    check("R2 upper control bits ignored", result, held);
    check("R2 model", result, exp);

    // R8: without inValid the register holds and outValid stays low
    held = result;
    fillFromSeed(16'h0BAD);
    @(negedge clk);
    @(negedge clk);
    check("R8 hold result", result, held);
    check("R8 outValid low", {511'b0, outValid}, 512'b0);

    // R3 R5: full mask in zeroing mode writes every byte
    maskEn = 1'b1; zeroMode = 1'b1; wrMask = '1;
    pulse(exp);
    check("R3 full mask", result, model(vecLen, 1'b0, 1'b0, 1'b0, '0, ctrlVec, dataVec, oldDest));

    // R5: empty mask in zeroing mode clears everything
    wrMask = '0;
    pulse(exp);
    check("R5 empty mask zeroes", result, '0);

    // R4: empty mask in merge mode copies oldDest over the active width
    zeroMode = 1'b0;
    pulse(exp);
    check("R4 empty mask merges", result, oldDest);

    // R9: reset mid-run clears a nonzero result
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid-run reset", result, '0);
    check("R9 mid-run outValid", {511'b0, outValid}, 512'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule